// File: doc/BRIEF.md
# Frame-Referenced Dead-Band Digital PLL

This block keeps a divided-down line clock in step with an 8 kHz frame reference. A master-rate phase is divided by 8 to give the line clock, and that line clock is divided again by a frame divisor. The divisor is 193 for a T1-rate line and 256 for a CEPT-rate line. The result is an internal 8 kHz frame level. Once per reference falling edge the block looks at two things: the frame level and a correction-window signal that is low over a narrow dead band. Outside the dead band it moves its phase by half a master period. When the frame level is high it advances the phase, and when it is low it retards it. Inside the dead band it leaves the phase alone. Slow jitter and wander that stay within the dead band are therefore not tracked.

The block runs on a clock at twice the master rate, so one clock cycle equals half a master period. A stretch holds the phase for one cycle. A shrink moves the phase forward by two half-periods in one cycle. A separate divide mode bypasses the loop. In that mode it counts rising edges of an external line clock and divides them by 193 or 256 to produce the frame level.

Top module: `frame_dpll`

## Requirements
- R1: While rstN is low, the phase counter and the divide-mode counter are held at zero and no correction is pending. In loop mode frame8k reads 1, corrWindow reads 1 and lineClkEn reads 0.
- R2: With no correction, the phase h (in half-master-periods, 0 to 16·FRAME_DIV−1) advances by one every clock. The first edge after reset gives h=1. lineClkEn pulses in any cycle whose step carries h across a multiple of 16, which gives one pulse per 8 master periods.
- R3: frame8k is 1 exactly when h < 8·FRAME_DIV. corrWindow is 0 exactly when 8·FRAME_DIV − CS_LOW_MASTER ≤ h < 8·FRAME_DIV + CS_LOW_MASTER, which is a dead band of CS_LOW_MASTER master periods centred on the fall of frame8k.
- R4: frameRef passes through two synchronizer flops. A low level that is first captured at clock edge k is detected as a falling edge using the h held after edge k+1. Any correction is applied at edge k+3.
- R5: If the detected edge saw corrWindow=1 and frame8k=1, the phase is shrunk: it steps by two (modulo the frame) in that one cycle.
- R6: If the detected edge saw corrWindow=1 and frame8k=0, the phase is stretched: it holds for one cycle.
- R7: If the detected edge saw corrWindow=0, no correction is made.
- R8: Rising edges of frameRef and a static frameRef level cause no correction, so the loop free-runs.
- R9: Each falling edge yields at most one correction, even when frameRef stays low for a whole frame afterwards.
- R10: With bypassDiv=1, corrWindow is 0 and lineClkEn gives one pulse for each rising edge of extLineClk. frame8k is 1 while the number of earlier pulses, modulo D, is below D/2 (rounded down). D is 193 when divSel256=0 and 256 when divSel256=1.
- R11: With bypassDiv=1, frameRef edges cause no correction. The loop phase keeps free-running, so after bypassDiv returns to 0 the phase is the cycle count since reset, modulo the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master rate |
| rstN | input | 1 | Asynchronous active-low reset |
| frameRef | input | 1 | Asynchronous 8 kHz frame reference |
| bypassDiv | input | 1 | 1 selects divide mode, 0 selects loop mode |
| divSel256 | input | 1 | Divide-mode divisor: 0 gives 193, 1 gives 256 |
| extLineClk | input | 1 | Asynchronous external line clock for divide mode |
| lineClkEn | output | 1 | One-cycle line-clock enable |
| frame8k | output | 1 | Internal 8 kHz frame level |
| corrWindow | output | 1 | Correction window; low over the dead band |

## Verification
A correction step can land in the same cycle as a line boundary or a frame wrap. A shrink taken at h=14 or h=15 must still raise lineClkEn. A stretch taken at h=15 must suppress that cycle's pulse. A stretch at the last phase of the frame must delay the wrap. The bench provokes every such case on a small frame: it places one reference falling edge at each of the frame's phases in turn, then compares lineClkEn, frame8k and corrWindow in every cycle against a phase computed arithmetically from the expected step.

// File: rtl/frame_dpll_pkg.sv
`timescale 1ns/1ps
package frame_dpll_pkg;

  // Correction strobes passed from control to datapath, valid for one cycle.
  typedef struct packed {
    logic stretch;  // hold the phase for one cycle
    logic shrink;   // advance the phase by two half-periods
  } corrStrobe_t;

  // One master period spans two cycles of the block clock.
  localparam int HALF_PER_MASTER = 2;

endpackage

// File: rtl/frame_dpll_ctrl.sv
`timescale 1ns/1ps
module frame_dpll_ctrl
  import frame_dpll_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameRef,
  input  logic        extLineClk,
  input  logic        bypassDiv,
  input  logic        loopFrame,
  input  logic        loopWindow,
  output corrStrobe_t corr,
  output logic        extRise
);

  // Synchronizer stages plus one history flop for edge detection.
  logic [SYNC_DEPTH:0] refPipe;
  logic [SYNC_DEPTH:0] extPipe;
  logic                refFall;
  logic                corrArm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPipe <= '0;
      extPipe <= '0;
    end else begin
      refPipe <= {refPipe[SYNC_DEPTH-1:0], frameRef};
      extPipe <= {extPipe[SYNC_DEPTH-1:0], extLineClk};
    end
  end

  assign refFall = refPipe[SYNC_DEPTH] & ~refPipe[SYNC_DEPTH-1];
  assign extRise = extPipe[SYNC_DEPTH-1] & ~extPipe[SYNC_DEPTH];

  // A correction is armed only outside the dead band and only in loop mode.
  assign corrArm = refFall && !bypassDiv && loopWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      corr <= '0;
    end else begin
      corr.stretch <= corrArm && !loopFrame;
      corr.shrink  <= corrArm && loopFrame;
    end
  end

endmodule

// File: rtl/frame_dpll_dp.sv
`timescale 1ns/1ps
module frame_dpll_dp
  import frame_dpll_pkg::*;
#(
  parameter int FRAME_DIV       = 193,
  parameter int MASTER_PER_LINE = 8,
  parameter int CS_LOW_MASTER   = 4,
  parameter int DIV_LO          = 193,
  parameter int DIV_HI          = 256,
  localparam int LINE_H  = HALF_PER_MASTER * MASTER_PER_LINE,
  localparam int FRAME_H = LINE_H * FRAME_DIV,
  localparam int PH_W    = $clog2(FRAME_H)
) (
  input  logic            clk,
  input  logic            rstN,
  input  corrStrobe_t     corr,
  input  logic            extRise,
  input  logic            divSel256,
  output logic [PH_W-1:0] phase,
  output logic            lineTick,
  output logic            loopFrame,
  output logic            loopWindow,
  output logic            divFrame
);

  localparam int LINE_W  = $clog2(LINE_H);
  localparam int MID_H   = FRAME_H / 2;
  localparam int WIN_LO  = MID_H - CS_LOW_MASTER;
  localparam int WIN_HI  = MID_H + CS_LOW_MASTER;
  localparam int DIV_MAX = (DIV_HI > DIV_LO) ? DIV_HI : DIV_LO;
  localparam int DC_W    = $clog2(DIV_MAX);

  // ---------------- loop phase counter (half-master-period units)
  logic [1:0]      step;
  logic [PH_W:0]   phaseSum;
  logic [PH_W-1:0] phaseNext;
  logic [LINE_W:0] lineSum;

  always_comb begin
    if (corr.stretch)     step = 2'd0;
    else if (corr.shrink) step = 2'd2;
    else                  step = 2'd1;
    phaseSum = {1'b0, phase} + {{(PH_W-1){1'b0}}, step};
    if (phaseSum >= (PH_W+1)'(FRAME_H))
      phaseNext = PH_W'(phaseSum - (PH_W+1)'(FRAME_H));
    else
      phaseNext = PH_W'(phaseSum);
    lineSum = {1'b0, phase[LINE_W-1:0]} + (LINE_W+1)'(step);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phaseNext;
  end

  // A line boundary is crossed whenever this cycle's step carries past it.
  assign lineTick   = (lineSum >= (LINE_W+1)'(LINE_H));
  assign loopFrame  = (phase < PH_W'(MID_H));
  assign loopWindow = !((phase >= PH_W'(WIN_LO)) && (phase < PH_W'(WIN_HI)));

  // ---------------- divide-mode counter
  logic [DC_W-1:0] divCnt;
  logic [DC_W-1:0] divLimit;
  logic [DC_W-1:0] divHalf;

  always_comb begin
    if (divSel256) begin
      divLimit = DC_W'(DIV_HI - 1);
      divHalf  = DC_W'(DIV_HI / 2);
    end else begin
      divLimit = DC_W'(DIV_LO - 1);
      divHalf  = DC_W'(DIV_LO / 2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (extRise) begin
      if (divCnt >= divLimit) divCnt <= '0;
      else                    divCnt <= divCnt + 1'b1;
    end
  end

  assign divFrame = (divCnt < divHalf);

endmodule

// File: rtl/frame_dpll.sv
`timescale 1ns/1ps
module frame_dpll
  import frame_dpll_pkg::*;
#(
  parameter int FRAME_DIV       = 193,
  parameter int MASTER_PER_LINE = 8,
  parameter int CS_LOW_MASTER   = 4,
  parameter int DIV_LO          = 193,
  parameter int DIV_HI          = 256,
  parameter int SYNC_DEPTH      = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameRef,
  input  logic bypassDiv,
  input  logic divSel256,
  input  logic extLineClk,
  output logic lineClkEn,
  output logic frame8k,
  output logic corrWindow
);

  localparam int LINE_H  = HALF_PER_MASTER * MASTER_PER_LINE;
  localparam int FRAME_H = LINE_H * FRAME_DIV;
  localparam int PH_W    = $clog2(FRAME_H);

  corrStrobe_t     corr;
  logic            extRise;
  logic [PH_W-1:0] phase;
  logic            lineTick;
  logic            loopFrame;
  logic            loopWindow;
  logic            divFrame;

  frame_dpll_ctrl #(
    .SYNC_DEPTH(SYNC_DEPTH)
  ) ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .frameRef   (frameRef),
    .extLineClk (extLineClk),
    .bypassDiv  (bypassDiv),
    .loopFrame  (loopFrame),
    .loopWindow (loopWindow),
    .corr       (corr),
    .extRise    (extRise)
  );

  frame_dpll_dp #(
    .FRAME_DIV       (FRAME_DIV),
    .MASTER_PER_LINE (MASTER_PER_LINE),
    .CS_LOW_MASTER   (CS_LOW_MASTER),
    .DIV_LO          (DIV_LO),
    .DIV_HI          (DIV_HI)
  ) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .corr       (corr),
    .extRise    (extRise),
    .divSel256  (divSel256),
    .phase      (phase),
    .lineTick   (lineTick),
    .loopFrame  (loopFrame),
    .loopWindow (loopWindow),
    .divFrame   (divFrame)
  );

  assign lineClkEn  = bypassDiv ? extRise  : lineTick;
  assign frame8k    = bypassDiv ? divFrame : loopFrame;
  assign corrWindow = !bypassDiv && loopWindow;

endmodule

// File: rtl/frame_dpll_checker.sv
`timescale 1ns/1ps
module frame_dpll_checker #(
  parameter int FRAME_H = 3088,
  parameter int PH_W    = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            bypassDiv,
  input logic            divSel256,
  input logic            lineClkEn,
  input logic            frame8k,
  input logic            corrWindow,
  input logic [PH_W-1:0] phase,
  input logic            stretch,
  input logic            shrink
);

  // R2: without a strobe the datapath moves one half-period
  assert_normal_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stretch && !shrink) |=> int'(phase) == (int'($past(phase)) + 1) % FRAME_H);

  // R5: a shrink strobe makes the phase jump by two
  assert_shrink_skip_R5: assert property (@(posedge clk) disable iff (!rstN)
    (shrink && !stretch) |=> int'(phase) == (int'($past(phase)) + 2) % FRAME_H);

  // R5: a shrink is only chosen while the frame level was high
  assert_shrink_dir_R5: assert property (@(posedge clk) disable iff (!rstN)
    shrink |-> $past(frame8k));

  // R6: a stretch strobe freezes the phase for one cycle
  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    stretch |=> $stable(phase));

  // R6: a stretch is only chosen while the frame level was low
  assert_stretch_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    stretch |-> !$past(frame8k));

  // R7: no strobe unless the window was open when sampled
  assert_window_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stretch || shrink) |-> $past(corrWindow));

  // R9: strobes never come on consecutive cycles
  assert_single_corr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stretch || shrink) |=> !(stretch || shrink));

  // R11: divide mode blocks all corrections
  assert_bypass_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    bypassDiv |=> !(stretch || shrink));

  // R10: the divided frame level only moves after a line pulse
  assert_div_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bypassDiv && !lineClkEn) ##1 (bypassDiv && $stable(divSel256)) |-> $stable(frame8k));

endmodule

bind frame_dpll frame_dpll_checker #(
  .FRAME_H (FRAME_H),
  .PH_W    (PH_W)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .bypassDiv  (bypassDiv),
  .divSel256  (divSel256),
  .lineClkEn  (lineClkEn),
  .frame8k    (frame8k),
  .corrWindow (corrWindow),
  .phase      (phase),
  .stretch    (corr.stretch),
  .shrink     (corr.shrink)
);

// File: tb/frame_dpll_test.sv
`timescale 1ns/1ps
module frame_dpll_test;

  localparam int N  = 5;        // small frame divisor
  localparam int W  = 2;        // dead band in master periods
  localparam int FH = 16 * N;   // frame length in half-periods
  localparam int MID = FH / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameRef = 1'b1;
  logic bypassDiv = 1'b0;
  logic divSel256 = 1'b0;
  logic extLineClk = 1'b0;
  wire  lineClkEn;
  wire  frame8k;
  wire  corrWindow;

  int checks = 0;
  int fails = 0;
  int jc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_dpll #(
    .FRAME_DIV(N), .MASTER_PER_LINE(8), .CS_LOW_MASTER(W),
    .DIV_LO(193), .DIV_HI(256), .SYNC_DEPTH(2)
  ) uut (
    .clk(clk), .rstN(rstN), .frameRef(frameRef), .bypassDiv(bypassDiv),
    .divSel256(divSel256), .extLineClk(extLineClk),
    .lineClkEn(lineClkEn), .frame8k(frame8k), .corrWindow(corrWindow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, jc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    jc++;
    @(negedge clk);
  endtask

  // R1: hold reset, check the idle outputs, release between edges
  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frame8k === 1'b1, "R1 frame level in reset", int'(frame8k), 1);
    chk(corrWindow === !bypassDiv, "R1 window in reset", int'(corrWindow), int'(!bypassDiv));
    chk(lineClkEn === 1'b0, "R1 line enable in reset", int'(lineClkEn), 0);
    rstN = 1'b1;
    jc = 0;
  endtask

  // Loop-mode outputs for phase h and the step taken in this cycle (R2, R3)
  task automatic checkLoop(input int h, input int step, input string req);
    bit fExp, wExp, lExp;
    fExp = (h < MID);
    wExp = !((h >= MID - W) && (h < MID + W));
    lExp = ((h % 16) + step) >= 16;
    chk(frame8k === fExp, {req, " frame level"}, int'(frame8k), int'(fExp));
    chk(corrWindow === wExp, {req, " window"}, int'(corrWindow), int'(wExp));
    chk(lineClkEn === lExp, {req, " line enable"}, int'(lineClkEn), int'(lExp));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    // Sweep: one reference fall sampled at each phase of the frame (R4..R9)
    for (int p = 0; p < FH; p++) begin
      int k;
      int d;
      string tag;
      frameRef = 1'b1;
      bypassDiv = 1'b0;
      doReset();
      k = p - 1 + FH;
      d = 0;
      if (p < MID - W || p >= MID + W) d = (p < MID) ? 1 : -1;
      tag = (d > 0) ? "R5" : ((d < 0) ? "R6" : "R7");
      for (int n = 0; n < k + 3 + FH; n++) begin
        tick();
        if (jc <= k + 1)      checkLoop(jc % FH, 1, "R2 R3 R8");
        else if (jc == k + 2) checkLoop(jc % FH, 1 + d, {"R4 ", tag});
        else                  checkLoop((jc + d + FH) % FH, 1, {tag, " R9"});
        if (jc == k - 1) frameRef = 1'b0;
      end
    end

    // R8: a rising reference edge leaves the loop free-running
    frameRef = 1'b0;
    bypassDiv = 1'b0;
    doReset();
    for (int n = 0; n < 2 * FH; n++) begin
      tick();
      checkLoop(jc % FH, 1, "R8");
      if (jc == 30) frameRef = 1'b1;
    end

    // R10, R11: divide mode with both divisors, reference toggling meanwhile
    for (int s = 0; s < 2; s++) begin
      int dv;
      int pulses;
      int edges;
      dv = (s != 0) ? 256 : 193;
      bypassDiv = 1'b1;
      divSel256 = (s != 0);
      extLineClk = 1'b0;
      frameRef = 1'b1;
      doReset();
      pulses = 0;
      edges = 0;
      for (int n = 0; n < 4 * (2 * dv + 3); n++) begin
        tick();
        chk(corrWindow === 1'b0, "R10 window low in divide mode", int'(corrWindow), 0);
        chk(frame8k === ((pulses % dv) < dv / 2), "R10 divided frame level",
            int'(frame8k), int'((pulses % dv) < dv / 2));
        if (lineClkEn) pulses++;
        extLineClk = ((n % 4) < 2);
        if (n % 4 == 0) edges++;
        if (n % 7 == 0) frameRef = ~frameRef;
      end
      extLineClk = 1'b0;
      frameRef = 1'b1;
      repeat (8) begin
        tick();
        if (lineClkEn) pulses++;
      end
      chk(pulses == edges, "R10 one pulse per external rising edge", pulses, edges);
      bypassDiv = 1'b0;
      for (int n = 0; n < FH + 16; n++) begin
        tick();
        checkLoop(jc % FH, 1, "R11");
      end
    end

    finishRun();
  end

endmodule